// File: doc/BRIEF.md
# Secure Chunk Fetch and Tag-Check Controller

This controller sits between an instruction cache and off-chip memory that holds compressed, encrypted code. When the cache misses, the controller turns the line address into the location of a 128-bit chunk plus the bit at which that line's compressed form begins inside it. It uses an on-chip translation table for this. It then reads the chunk from memory and passes it to an external decryption engine. The result is accepted only when the address tag recovered from the plaintext equals the chunk address. Only then does the line decompressor start.

Several cache lines can share one chunk. For that reason the controller keeps the last verified chunk in a buffer. A later miss that translates to the same chunk address skips both the memory read and the decryption. When the recovered tag does not match, the controller raises a one-cycle integrity error and discards the buffer. Memory and the cipher are external, and both answer through request/acknowledge handshakes of any latency. One miss is handled at a time.

Top module: `chunk_fetch_ctrl`

## Requirements
- R1: After synchronous reset, busy, mem_req, dec_req, dcmp_start and integ_err are low, and the chunk buffer is empty, so the first miss always reads memory.
- R2: The table is written through tbl_we, tbl_idx, tbl_chunk and tbl_off. An accepted miss is indexed by miss_addr bits [9:4] (16-byte lines, 64 entries by default). The stored chunk address is presented on mem_addr while mem_req is high.
- R3: mem_addr stays constant for as long as mem_req is high, and mem_req stays high until mem_ack.
- R4: On the cycle mem_ack is high, mem_rdata is captured. From the next cycle dec_req is high with that value on dec_din, held until dec_ack.
- R5: On the cycle dec_ack is high, the decryption is complete. If dec_dout bits [31:0] equal the chunk address, dcmp_start pulses for one cycle on the next cycle. At that point dcmp_off carries the table offset and dcmp_chunk the plaintext.
- R6: If the tag does not match, integ_err pulses for one cycle instead of dcmp_start, and the buffer is emptied. A following miss to the same chunk reads memory again.
- R7: A miss whose chunk address equals the buffered, verified chunk raises neither mem_req nor dec_req. dcmp_start pulses on the next cycle with that miss's own offset.
- R8: A miss is accepted only when busy is low. busy is high from the cycle after a fetching miss is accepted until the cycle after dec_ack. miss_valid while busy has no effect.
- R9: dcmp_start and integ_err are never high together, and mem_req and dec_req are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Write one translation entry |
| tbl_idx | input | IDX_W | Entry to write |
| tbl_chunk | input | 32 | Chunk address for the entry |
| tbl_off | input | 7 | Start bit of the compressed line in the chunk |
| miss_valid | input | 1 | Cache miss request |
| miss_addr | input | 32 | Byte address of the missing line |
| busy | output | 1 | A fetch is in progress; misses are not accepted |
| mem_req | output | 1 | Chunk read request |
| mem_addr | output | 32 | Chunk address to read |
| mem_ack | input | 1 | Memory data valid |
| mem_rdata | input | 128 | Encrypted chunk |
| dec_req | output | 1 | Decryption request |
| dec_din | output | 128 | Ciphertext to decrypt |
| dec_ack | input | 1 | Plaintext valid |
| dec_dout | input | 128 | Decrypted chunk, tag in bits [31:0] |
| dcmp_start | output | 1 | Start the decompressor |
| dcmp_off | output | 7 | Start bit for the decompressor |
| dcmp_chunk | output | 128 | Verified plaintext chunk |
| integ_err | output | 1 | Tag mismatch pulse |

## Verification
On every cycle the assertions check the mutual exclusion of the handshakes and of the result pulses. They also check that the address and ciphertext stay stable while a request is open, and that every integrity error follows a completed decryption. Only the bench's scenarios can show the rest. These are the translation through the table, the reuse of a buffered chunk without any memory traffic, the discarding of the buffer after a tampered chunk, and that a miss presented while busy leaves no trace. The bench runs them at two memory latencies against its own model of the controller.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

    localparam int ADDR_W  = 32;
    localparam int CHUNK_W = 128;
    localparam int OFF_W   = $clog2(CHUNK_W);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_DECRYPT = 2'd2
    } cfc_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] chunk;
        logic [OFF_W-1:0]  off;
    } xlat_entry_t;

    function automatic logic [ADDR_W-1:0] tag_field(input logic [CHUNK_W-1:0] plain);
        return plain[ADDR_W-1:0];
    endfunction

endpackage

// File: rtl/cfc_xlat_table.sv
module cfc_xlat_table
    import cfc_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  xlat_entry_t             wr_entry,
    input  logic [IDX_W-1:0]        rd_idx,
    output xlat_entry_t             rd_entry
);
    localparam int DEPTH = 1 << IDX_W;

    xlat_entry_t entries [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            entries[wr_idx] <= wr_entry;
        end
    end

    assign rd_entry = entries[rd_idx];

endmodule

// File: rtl/cfc_tag_check.sv
module cfc_tag_check
    import cfc_pkg::*;
(
    input  logic [CHUNK_W-1:0] plain,
    input  logic [ADDR_W-1:0]  expect_addr,
    output logic               tag_ok
);
    assign tag_ok = (tag_field(plain) == expect_addr);
endmodule

// File: rtl/cfc_chunk_buf.sv
module cfc_chunk_buf
    import cfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fill,
    input  logic               drop,
    input  logic [ADDR_W-1:0]  fill_addr,
    input  logic [CHUNK_W-1:0] fill_data,
    input  logic [ADDR_W-1:0]  probe_addr,
    output logic               hit,
    output logic [CHUNK_W-1:0] data
);
    logic              held_valid;
    logic [ADDR_W-1:0] held_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            held_addr  <= '0;
            data       <= '0;
        end else if (fill) begin
            held_valid <= 1'b1;
            held_addr  <= fill_addr;
            data       <= fill_data;
        end else if (drop) begin
            held_valid <= 1'b0;
        end
    end

    assign hit = held_valid && (held_addr == probe_addr);
endmodule

// File: rtl/chunk_fetch_ctrl.sv
module chunk_fetch_ctrl
    import cfc_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int LINE_OFF_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [ADDR_W-1:0]  tbl_chunk,
    input  logic [OFF_W-1:0]   tbl_off,
    input  logic               miss_valid,
    input  logic [ADDR_W-1:0]  miss_addr,
    output logic               busy,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_ack,
    input  logic [CHUNK_W-1:0] mem_rdata,
    output logic               dec_req,
    output logic [CHUNK_W-1:0] dec_din,
    input  logic               dec_ack,
    input  logic [CHUNK_W-1:0] dec_dout,
    output logic               dcmp_start,
    output logic [OFF_W-1:0]   dcmp_off,
    output logic [CHUNK_W-1:0] dcmp_chunk,
    output logic               integ_err
);
    localparam int IDX_LO = LINE_OFF_W;
    localparam int IDX_HI = LINE_OFF_W + IDX_W - 1;

    cfc_state_e         state;
    xlat_entry_t        wr_entry;
    xlat_entry_t        lookup;
    logic [IDX_W-1:0]   miss_idx;
    logic [ADDR_W-1:0]  cmp_addr;
    logic [OFF_W-1:0]   cmp_off;
    logic [CHUNK_W-1:0] cipher_q;
    logic               buf_hit;
    logic               tag_ok;
    logic               accept;
    logic               dec_done;
    logic               unused_addr_bits;

    assign miss_idx         = miss_addr[IDX_HI:IDX_LO];
    assign unused_addr_bits = ^{miss_addr[ADDR_W-1:IDX_HI+1], miss_addr[IDX_LO-1:0]};
    assign wr_entry         = '{chunk: tbl_chunk, off: tbl_off};

    cfc_xlat_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_entry (wr_entry),
        .rd_idx   (miss_idx),
        .rd_entry (lookup)
    );

    cfc_tag_check u_tag (
        .plain       (dec_dout),
        .expect_addr (cmp_addr),
        .tag_ok      (tag_ok)
    );

    assign accept   = (state == ST_IDLE) && miss_valid;
    assign dec_done = (state == ST_DECRYPT) && dec_ack;

    cfc_chunk_buf u_buf (
        .clk        (clk),
        .rst        (rst),
        .fill       (dec_done && tag_ok),
        .drop       (dec_done && !tag_ok),
        .fill_addr  (cmp_addr),
        .fill_data  (dec_dout),
        .probe_addr (lookup.chunk),
        .hit        (buf_hit),
        .data       (dcmp_chunk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cmp_addr   <= '0;
            cmp_off    <= '0;
            cipher_q   <= '0;
            dcmp_start <= 1'b0;
            integ_err  <= 1'b0;
        end else begin
            dcmp_start <= 1'b0;
            integ_err  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cmp_addr <= lookup.chunk;
                        cmp_off  <= lookup.off;
                        if (buf_hit) begin
                            dcmp_start <= 1'b1;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        cipher_q <= mem_rdata;
                        state    <= ST_DECRYPT;
                    end
                end
                ST_DECRYPT: begin
                    if (dec_ack) begin
                        state <= ST_IDLE;
                        if (tag_ok) begin
                            dcmp_start <= 1'b1;
                        end else begin
                            integ_err <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign mem_req  = (state == ST_FETCH);
    assign mem_addr = cmp_addr;
    assign dec_req  = (state == ST_DECRYPT);
    assign dec_din  = cipher_q;
    assign dcmp_off = cmp_off;

endmodule

// File: rtl/cfc_checker.sv
module cfc_checker
    import cfc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               mem_req,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               mem_ack,
    input logic               dec_req,
    input logic [CHUNK_W-1:0] dec_din,
    input logic               dec_ack,
    input logic               dcmp_start,
    input logic               integ_err
);
    a_r9_result_excl: assert property (@(posedge clk) disable iff (rst)
        !(dcmp_start && integ_err));

    a_r9_req_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && dec_req));

    a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r4_din_stable: assert property (@(posedge clk) disable iff (rst)
        (dec_req && !dec_ack) |=> (dec_req && $stable(dec_din)));

    a_r4_dec_follows_mem: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> dec_req);

    a_r6_err_after_dec: assert property (@(posedge clk) disable iff (rst)
        integ_err |-> $past(dec_req && dec_ack));

    a_r8_busy_covers: assert property (@(posedge clk) disable iff (rst)
        (mem_req || dec_req) |-> busy);
endmodule

bind chunk_fetch_ctrl cfc_checker u_cfc_checker (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .dec_req    (dec_req),
    .dec_din    (dec_din),
    .dec_ack    (dec_ack),
    .dcmp_start (dcmp_start),
    .integ_err  (integ_err)
);

// File: tb/chunk_fetch_ctrl_tb.sv
module chunk_fetch_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 6;
    localparam logic [127:0] KEY_MASK = 128'h5a3c_96e1_0f27_b4d8_c3a5_7e19_62f0_8bd4;
    localparam logic [31:0]  TAMPERED = 32'h0000_1020;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tbl_we = 1'b0;
    logic [5:0]   tbl_idx = '0;
    logic [31:0]  tbl_chunk = '0;
    logic [6:0]   tbl_off = '0;
    logic         miss_valid = 1'b0;
    logic [31:0]  miss_addr = '0;
    logic         busy, mem_req, dec_req, dcmp_start, integ_err;
    logic [31:0]  mem_addr;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rdata = '0;
    logic [127:0] dec_din;
    logic         dec_ack = 1'b0;
    logic [127:0] dec_dout = '0;
    logic [6:0]   dcmp_off;
    logic [127:0] dcmp_chunk;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int mem_lat = 2;
    int mcnt = 0;
    int dcnt = 0;
    int fetch_cnt = 0;
    int err_cnt = 0;
    int start_cnt = 0;

    // reference model state
    int           m_ph = 0;
    logic         m_bvalid = 1'b0;
    logic [31:0]  m_baddr = '0;
    logic [127:0] m_bdata = '0;
    logic [31:0]  m_ca = '0;
    logic [6:0]   m_off = '0;
    logic [127:0] m_ciph = '0;
    logic         m_start = 1'b0;
    logic         m_err = 1'b0;
    logic [31:0]  m_tc [64];
    logic [6:0]   m_to [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    chunk_fetch_ctrl #(.IDX_W(IDX_W), .LINE_OFF_W(4)) dut_i (
        .clk(clk), .rst(rst),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_chunk(tbl_chunk), .tbl_off(tbl_off),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dec_req(dec_req), .dec_din(dec_din), .dec_ack(dec_ack), .dec_dout(dec_dout),
        .dcmp_start(dcmp_start), .dcmp_off(dcmp_off), .dcmp_chunk(dcmp_chunk),
        .integ_err(integ_err)
    );

    function automatic logic [127:0] plain_of(input logic [31:0] a);
        return {a * 32'd3 ^ 32'h0000_c0de, a + 32'd7, ~a, a};
    endfunction

    function automatic logic [127:0] cipher_of(input logic [31:0] a);
        logic [127:0] c;
        c = plain_of(a) ^ KEY_MASK;
        if (a == TAMPERED) c[3] = ~c[3];
        return c;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // reference model, updated on the same edge the design samples
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_ph = 0; m_bvalid = 1'b0; m_start = 1'b0; m_err = 1'b0;
        end else begin
            m_start = 1'b0;
            m_err   = 1'b0;
            if (m_ph == 0) begin
                if (miss_valid) begin
                    m_ca  = m_tc[miss_addr[9:4]];
                    m_off = m_to[miss_addr[9:4]];
                    if (m_bvalid && m_baddr == m_ca) m_start = 1'b1;
                    else m_ph = 1;
                end
            end else if (m_ph == 1) begin
                if (mem_ack) begin m_ciph = mem_rdata; m_ph = 2; end
            end else begin
                if (dec_ack) begin
                    m_ph = 0;
                    if (dec_dout[31:0] == m_ca) begin
                        m_bvalid = 1'b1; m_baddr = m_ca; m_bdata = dec_dout; m_start = 1'b1;
                    end else begin
                        m_bvalid = 1'b0; m_err = 1'b1;
                    end
                end
            end
            if (tbl_we) begin
                m_tc[tbl_idx] = tbl_chunk;
                m_to[tbl_idx] = tbl_off;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R8 busy", busy, m_ph != 0);
            check("R2 mem_req", mem_req, m_ph == 1);
            check("R4 dec_req", dec_req, m_ph == 2);
            check("R5/R7 dcmp_start", dcmp_start, m_start);
            check("R6 integ_err", integ_err, m_err);
            if (m_ph == 1) check("R3 mem_addr", mem_addr, m_ca);
            if (m_ph == 2) check("R4 dec_din", dec_din, m_ciph);
            if (m_start) begin
                check("R5 dcmp_off", dcmp_off, m_off);
                check("R5 dcmp_chunk", dcmp_chunk, m_bdata);
            end
            if (dcmp_start) start_cnt++;
            if (integ_err) err_cnt++;
        end
    end

    // memory and cipher responders
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0; dec_ack = 1'b0; mcnt = 0; dcnt = 0;
        end else begin
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (mcnt >= mem_lat) begin
                    mem_ack = 1'b1; mem_rdata = cipher_of(mem_addr); mcnt = 0; fetch_cnt++;
                end else mcnt++;
            end else mcnt = 0;
            if (dec_ack) dec_ack = 1'b0;
            else if (dec_req) begin
                if (dcnt >= 5) begin
                    dec_ack = 1'b1; dec_dout = dec_din ^ KEY_MASK; dcnt = 0;
                end else dcnt++;
            end else dcnt = 0;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 50000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected below 50000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic write_entry(input int idx, input logic [31:0] ca, input logic [6:0] off);
        tbl_we = 1'b1; tbl_idx = idx[5:0]; tbl_chunk = ca; tbl_off = off;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic miss(input int line, input int stray_line);
        miss_valid = 1'b1;
        miss_addr  = 32'h4000_0000 | (line << 4) | 32'h4;
        @(negedge clk);
        miss_valid = 1'b0;
        if (stray_line >= 0) begin
            @(negedge clk);
            miss_valid = 1'b1;  // R8: offered while busy, must be ignored
            miss_addr  = 32'h4000_0000 | (stray_line << 4);
            @(negedge clk);
            miss_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 1'b0);
        check("R1 mem_req", mem_req, 1'b0);
        check("R1 dcmp_start", dcmp_start, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        write_entry(0, 32'h1000, 7'd32);
        write_entry(1, 32'h1000, 7'd74);
        write_entry(2, 32'h1010, 7'd32);
        write_entry(3, TAMPERED, 7'd32);
        write_entry(4, 32'h1000, 7'd100);
        write_entry(63, 32'h1030, 7'd40);
        miss(0, -1);          // R1/R2: first miss fetches
        miss(1, -1);          // R7: same chunk, reuse
        mem_lat = 7;
        miss(2, -1);          // R2: other chunk
        miss(0, -1);          // R2: refetch chunk A
        miss(3, -1);          // R6: tampered
        miss(3, -1);          // R6: fetched again
        mem_lat = 2;
        miss(2, 1);           // R6 buffer dropped; R8 stray miss ignored
        miss(2, -1);          // R7: reuse chunk B
        miss(4, -1);          // R2: chunk A, third offset
        miss(63, -1);         // R2: top index
        miss(63, -1);         // R7
        check("R7 fetch count", fetch_cnt, 8);
        check("R6 error count", err_cnt, 2);
        check("R5 start count", start_cnt, 9);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule